// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller decides which power mode a processor's clock domain is in. The modes are normal-high, normal-low, doze-high, doze-low, sleep, deep-sleep and power-down. Software requests a mode with a strobe. From then on the controller moves between the modes by itself. Three things drive it: coprocessor activity, the power-save bit, and the clock-switching enable. It also watches two kinds of wake source. One is a level-sensitive request from the interrupt controller. The other is four timer-class events, which are lumped together.

Each wake path has its own latency:
- A timer-class wake leaves a running low mode after a fixed number of fast clocks.
- An interrupt-controller wake waits for two ticks of the divided general clock.
- A deep-sleep exit waits for the PLL to lock, bounded by a down-counter timeout on the reference clock.

In power-down, a timer wake raises the timer-expired pin. An external hard-reset input then brings the clock domain back to full speed. The PLL, the dividers and the supply lie outside the block. They appear here only as a lock input, a divider select and a reference-tick enable.

Top module: `lp_mode_seq`

## Requirements
- R1: After power-on reset the mode reads normal-high (code 0), clk_hi and pll_en are 1, and both status flags and the timer-expired pin are 0.
- R2: Mode codes are 0 normal-high, 1 normal-low, 2 doze-high, 3 doze-low, 4 sleep, 5 deep-sleep, 6 power-down. A request (mode_req with mode_req_vld) takes effect on the next clock only when the mode is 0 or 1 and no wake is under way. Code 7 is ignored. clk_hi is 1 only in modes 0 and 2. pll_en is 0 in mode 6, and in mode 5 until a wake starts.
- R3: Any bit of tmr_evt sets twake_flag on the next clock. clr_stat bit 0 clears it, and a new event in the same cycle as the clear wins.
- R4: In modes 1 to 4 with no wake under way, a timer event or a set twake_flag starts a wake. The mode becomes 0 exactly 3 clocks after the recognising edge, and wake_lat then reads 3.
- R5: In modes 1 to 4, irq_req starts a wake that reaches mode 0 on the second tick of the general clock, which ticks every D = 2^div_sel clocks. wake_lat then reads between D+1 and 2D clocks.
- R6: In mode 1 with sw_en set, cop_act high or pwr_save low moves the mode to 0 on the next clock. With sw_en clear, mode 1 holds.
- R7: In mode 0 with sw_en set, the mode drops to 1 on the next clock when none of the following hold: cop_act, irq_req, twake_flag, pwr_save low, or a request.
- R8: cop_act high moves mode 3 to mode 2 on the next clock. With sw_en set, cop_act low moves mode 2 back to 3.
- R9: In mode 5, irq_req or a timer trigger turns pll_en on and starts the relock wait. pll_lock high during the wait moves the mode to 0 on that clock.
- R10: Without lock, the relock wait ends after 500 ref_tick pulses, or 1000 when one_to_one is set. The mode then becomes 0 and wake_lat holds the wait length.
- R11: In mode 6 a timer event sets texp_flag and raises tmr_exp_pin while the mode stays 6. hreset forces mode 0 on the next clock from any mode, and texp_flag is kept.
- R12: hreset in mode 6 with tmr_exp_pin low sets texp_flag and the pin, and enters mode 0.
- R13: A low mode entered while twake_flag is set does not hold. A wake starts on the next clock, and mode 0 returns 4 clocks after the request edge.
- R14: clr_stat bit 1 clears texp_flag and lowers tmr_exp_pin. It leaves twake_flag alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (VCO-rate) clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hreset | input | 1 | Synchronous external hard reset |
| mode_req | input | 3 | Requested mode code |
| mode_req_vld | input | 1 | Request strobe |
| sw_en | input | 1 | Automatic clock-switching enable |
| cop_act | input | 1 | Coprocessor active |
| pwr_save | input | 1 | Processor power-save bit |
| irq_req | input | 1 | Level-sensitive interrupt-controller wake |
| tmr_evt | input | 4 | Timer-class wake events |
| div_sel | input | DIV_W | General-clock divider exponent |
| ref_tick | input | 1 | Relock reference clock enable |
| one_to_one | input | 1 | Selects the longer relock limit |
| pll_lock | input | 1 | PLL lock indication |
| clr_stat | input | 2 | Write-one-to-clear: bit 0 twake, bit 1 texp |
| mode_o | output | 3 | Current mode code |
| clk_hi | output | 1 | High-frequency clock select |
| pll_en | output | 1 | PLL enable |
| tmr_exp_pin | output | 1 | Timer-expired pin |
| twake_flag | output | 1 | Sticky timer-wake status |
| texp_flag | output | 1 | Sticky timer-expired status |
| wake_lat | output | LAT_W | Cycles taken by the latest wake |

## Verification
Wakes are triggered from sleep, normal-low and doze-low, and from deep-sleep. This shows that the three latency paths differ: a fixed 3 cycles for timers, a count bound to the general-clock divider for interrupts (exactly 2 at divide-by-one, within 5 to 8 at divide-by-four), and lock-or-timeout for deep-sleep.

The automatic switching is driven in several ways:
- cop_act, pwr_save and sw_en are toggled one at a time, to show which condition moves normal-low, normal-high and the doze pair, and that sw_en gates the downward moves.
- Requests are sent in modes that must ignore them, and with the illegal code.
- A low mode is entered with the timer flag set.

Power-down is left both ways: after a timer expiry, and by hard reset with the pin low. This tells the two flag outcomes apart.

// File: rtl/lp_mode_seq.sv
module lp_mode_seq #(
  parameter int DIV_W        = 3,
  parameter int LAT_W        = 16,
  parameter int OSC_LIMIT    = 500,
  parameter int EXT_LIMIT    = 1000,
  parameter int TMR_WAKE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hreset,
  input  logic [2:0]       mode_req,
  input  logic             mode_req_vld,
  input  logic             sw_en,
  input  logic             cop_act,
  input  logic             pwr_save,
  input  logic             irq_req,
  input  logic [3:0]       tmr_evt,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             ref_tick,
  input  logic             one_to_one,
  input  logic             pll_lock,
  input  logic [1:0]       clr_stat,
  output logic [2:0]       mode_o,
  output logic             clk_hi,
  output logic             pll_en,
  output logic             tmr_exp_pin,
  output logic             twake_flag,
  output logic             texp_flag,
  output logic [LAT_W-1:0] wake_lat
);
  localparam logic [2:0] M_NH = 3'd0, M_NL = 3'd1, M_DH = 3'd2, M_DL = 3'd3,
                         M_SL = 3'd4, M_DS = 3'd5, M_PD = 3'd6;
  localparam logic [1:0] K_NONE = 2'd0, K_TMR = 2'd1, K_IRQ = 2'd2, K_RLK = 2'd3;
  localparam int RL_MAX = (EXT_LIMIT > OSC_LIMIT) ? EXT_LIMIT : OSC_LIMIT;
  localparam int RL_W   = $clog2(RL_MAX + 1);
  localparam int TC_W   = $clog2(TMR_WAKE_CYC + 1);
  localparam int PS_W   = (1 << DIV_W) - 1;

  logic [2:0]       mode_q;
  logic [1:0]       wk_kind;
  logic [TC_W-1:0]  tcnt;
  logic             gt_seen;
  logic [RL_W-1:0]  rl_cnt;
  logic [PS_W-1:0]  pcnt;
  logic [LAT_W-1:0] lat_q;
  logic             twake_q, texp_q;

  logic [PS_W-1:0] div_mask;
  logic gtick, tmr_any, tmr_trig, idle, low_run, up_cond;
  logic start_tmr, start_irq, start_rlk, req_ok, texp_set;

  assign div_mask  = ~({PS_W{1'b1}} << div_sel);
  assign gtick     = &(pcnt | ~div_mask);
  assign tmr_any   = |tmr_evt;
  assign tmr_trig  = tmr_any | twake_q;
  assign idle      = (wk_kind == K_NONE) && !hreset;
  assign low_run   = (mode_q == M_NL) || (mode_q == M_DH) ||
                     (mode_q == M_DL) || (mode_q == M_SL);
  assign up_cond   = cop_act | irq_req | ~pwr_save;
  assign start_tmr = idle && low_run && tmr_trig;
  assign start_irq = idle && low_run && !tmr_trig && irq_req;
  assign start_rlk = idle && (mode_q == M_DS) && (tmr_trig || irq_req);
  assign req_ok    = idle && mode_req_vld && mode_req != 3'd7 &&
                     ((mode_q == M_NH) || (mode_q == M_NL)) && !start_tmr && !start_irq;
  assign texp_set  = (mode_q == M_PD) && (tmr_any || (hreset && !texp_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_NH;
      wk_kind <= K_NONE;
      tcnt    <= '0;
      gt_seen <= 1'b0;
      rl_cnt  <= '0;
      pcnt    <= '0;
      lat_q   <= '0;
      twake_q <= 1'b0;
      texp_q  <= 1'b0;
    end else begin
      pcnt    <= pcnt + PS_W'(1);
      twake_q <= tmr_any | (twake_q & ~clr_stat[0]);
      texp_q  <= texp_set | (texp_q & ~clr_stat[1]);

      if (start_tmr || start_irq || start_rlk)
        lat_q <= '0;
      else if (wk_kind != K_NONE && !hreset && !(&lat_q))
        lat_q <= lat_q + LAT_W'(1);

      if (hreset) begin
        mode_q  <= M_NH;
        wk_kind <= K_NONE;
      end else begin
        case (wk_kind)
          K_NONE: begin
            if (start_tmr) begin
              wk_kind <= K_TMR;
              tcnt    <= TC_W'(TMR_WAKE_CYC - 1);
            end else if (start_irq) begin
              wk_kind <= K_IRQ;
              gt_seen <= 1'b0;
            end else if (start_rlk) begin
              wk_kind <= K_RLK;
              rl_cnt  <= one_to_one ? RL_W'(EXT_LIMIT) : RL_W'(OSC_LIMIT);
            end else if (req_ok) begin
              mode_q <= mode_req;
            end else begin
              case (mode_q)
                M_NH: if (sw_en && !up_cond && !twake_q) mode_q <= M_NL;
                M_NL: if (sw_en && (cop_act || !pwr_save)) mode_q <= M_NH;
                M_DL: if (cop_act) mode_q <= M_DH;
                M_DH: if (sw_en && !cop_act) mode_q <= M_DL;
                default: ;
              endcase
            end
          end
          K_TMR: begin
            if (tcnt == '0) begin
              mode_q  <= M_NH;
              wk_kind <= K_NONE;
            end else begin
              tcnt <= tcnt - TC_W'(1);
            end
          end
          K_IRQ: begin
            if (gtick) begin
              if (gt_seen) begin
                mode_q  <= M_NH;
                wk_kind <= K_NONE;
              end else begin
                gt_seen <= 1'b1;
              end
            end
          end
          default: begin
            if (pll_lock || (ref_tick && rl_cnt <= RL_W'(1))) begin
              mode_q  <= M_NH;
              wk_kind <= K_NONE;
            end else if (ref_tick) begin
              rl_cnt <= rl_cnt - RL_W'(1);
            end
          end
        endcase
      end
    end
  end

  assign mode_o      = mode_q;
  assign clk_hi      = (mode_q == M_NH) || (mode_q == M_DH);
  assign pll_en      = (mode_q != M_PD) && !((mode_q == M_DS) && (wk_kind != K_RLK));
  assign tmr_exp_pin = texp_q;
  assign twake_flag  = twake_q;
  assign texp_flag   = texp_q;
  assign wake_lat    = lat_q;
endmodule

// File: rtl/lp_mode_seq_chk.sv
module lp_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hreset,
  input logic [2:0] mode_o,
  input logic [1:0] wk_kind,
  input logic [3:0] tmr_evt,
  input logic       irq_req,
  input logic       cop_act,
  input logic       sw_en,
  input logic       pwr_save,
  input logic       mode_req_vld,
  input logic       pll_lock,
  input logic [1:0] clr_stat,
  input logic       twake_flag,
  input logic       texp_flag
);
  logic low_run;
  assign low_run = (mode_o == 3'd1) || (mode_o == 3'd2) || (mode_o == 3'd3) || (mode_o == 3'd4);

  AST_TWAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_evt) |=> twake_flag); // R3
  AST_TMR_WAKE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_kind == 2'd0 && !hreset && low_run && (|tmr_evt)) |=> ##3 (mode_o == 3'd0)); // R4
  AST_AUTO_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0 && wk_kind == 2'd0 && !hreset && sw_en && !cop_act && pwr_save &&
     !irq_req && !twake_flag && !mode_req_vld) |=> (mode_o == 3'd1)); // R7
  AST_DOZE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && wk_kind == 2'd0 && !hreset && cop_act && !irq_req &&
     !(|tmr_evt) && !twake_flag) |=> (mode_o == 3'd2)); // R8
  AST_RELOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5 && wk_kind == 2'd3 && pll_lock && !hreset) |=> (mode_o == 3'd0)); // R9
  AST_PDN_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd6 && (|tmr_evt)) |=> texp_flag); // R11
  AST_HRESET_NH: assert property (@(posedge clk) disable iff (!rst_n)
    hreset |=> (mode_o == 3'd0)); // R11
  AST_TEXP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (texp_flag && !clr_stat[1]) |=> texp_flag); // R14
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 3'd7); // R2
endmodule

bind lp_mode_seq lp_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hreset(hreset), .mode_o(mode_o), .wk_kind(wk_kind),
  .tmr_evt(tmr_evt), .irq_req(irq_req), .cop_act(cop_act), .sw_en(sw_en),
  .pwr_save(pwr_save), .mode_req_vld(mode_req_vld), .pll_lock(pll_lock),
  .clr_stat(clr_stat), .twake_flag(twake_flag), .texp_flag(texp_flag)
);

// File: tb/tb_lp_mode_seq.sv
`timescale 1ns/1ps
module tb_lp_mode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hreset = 1'b0;
  logic [2:0] mode_req = 3'd0;
  logic mode_req_vld = 1'b0;
  logic sw_en = 1'b0, cop_act = 1'b0, pwr_save = 1'b0, irq_req = 1'b0;
  logic [3:0] tmr_evt = 4'd0;
  logic [2:0] div_sel = 3'd0;
  logic ref_tick = 1'b0, one_to_one = 1'b0, pll_lock = 1'b0;
  logic [1:0] clr_stat = 2'd0;
  logic [2:0] mode_o;
  logic clk_hi, pll_en, tmr_exp_pin, twake_flag, texp_flag;
  logic [15:0] wake_lat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lp_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .hreset(hreset), .mode_req(mode_req),
    .mode_req_vld(mode_req_vld), .sw_en(sw_en), .cop_act(cop_act),
    .pwr_save(pwr_save), .irq_req(irq_req), .tmr_evt(tmr_evt), .div_sel(div_sel),
    .ref_tick(ref_tick), .one_to_one(one_to_one), .pll_lock(pll_lock),
    .clr_stat(clr_stat), .mode_o(mode_o), .clk_hi(clk_hi), .pll_en(pll_en),
    .tmr_exp_pin(tmr_exp_pin), .twake_flag(twake_flag), .texp_flag(texp_flag),
    .wake_lat(wake_lat)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(logic [2:0] m);
    mode_req = m; mode_req_vld = 1'b1; tick(1); mode_req_vld = 1'b0;
  endtask

  task automatic pulse_tmr(logic [3:0] v);
    tmr_evt = v; tick(1); tmr_evt = 4'd0;
  endtask

  task automatic clr(logic [1:0] v);
    clr_stat = v; tick(1); clr_stat = 2'd0;
  endtask

  task automatic hrst();
    hreset = 1'b1; tick(1); hreset = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode_o, 0);
    chk("R1 pll_en", pll_en, 1);
    chk("R1 clk_hi", clk_hi, 1);
    chk("R1 twake", twake_flag, 0);
    chk("R1 texp", texp_flag, 0);
    chk("R1 pin", tmr_exp_pin, 0);
  endtask

  task automatic t_requests();
    req(3'd7);
    chk("R2 code7 ignored", mode_o, 0);
    req(3'd4);
    chk("R2 sleep", mode_o, 4);
    chk("R2 sleep clk_hi", clk_hi, 0);
    chk("R2 sleep pll_en", pll_en, 1);
    req(3'd0);
    chk("R2 request in sleep ignored", mode_o, 4);
    hrst();
    req(3'd1);
    chk("R2 normal-low", mode_o, 1);
    chk("R2 normal-low clk_hi", clk_hi, 0);
    req(3'd0);
    chk("R2 back to normal-high", mode_o, 0);
  endtask

  task automatic t_flag();
    pulse_tmr(4'b1000);
    chk("R3 flag set", twake_flag, 1);
    chk("R3 mode unchanged", mode_o, 0);
    tmr_evt = 4'b0010; clr_stat = 2'b01; tick(1); tmr_evt = 4'd0; clr_stat = 2'd0;
    chk("R3 set beats clear", twake_flag, 1);
    clr(2'b01);
    chk("R3 cleared", twake_flag, 0);
  endtask

  task automatic t_tmr_wake();
    req(3'd4);
    pulse_tmr(4'b0100);
    tick(2);
    chk("R4 sleep held 2 clocks", mode_o, 4);
    tick(1);
    chk("R4 sleep wake at 3", mode_o, 0);
    chk("R4 latency", wake_lat, 3);
    clr(2'b01);
    req(3'd1);
    pulse_tmr(4'b0001);
    tick(2);
    chk("R4 normal-low held", mode_o, 1);
    tick(1);
    chk("R4 normal-low wake", mode_o, 0);
    clr(2'b01);
  endtask

  task automatic irq_wake(int d);
    int n = 0;
    req(3'd3);
    irq_req = 1'b1;
    while (mode_o != 3'd0 && n < 100) begin tick(1); n++; end
    irq_req = 1'b0;
    if (d == 1) chk("R5 latency div1", wake_lat, 2);
    else begin
      chk("R5 latency low bound", int'(wake_lat >= 16'(d + 1)), 1);
      chk("R5 latency high bound", int'(wake_lat <= 16'(2 * d)), 1);
    end
    chk("R5 cycles match latency", n, int'(wake_lat) + 1);
  endtask

  task automatic t_irq();
    div_sel = 3'd0; irq_wake(1);
    div_sel = 3'd2; irq_wake(4);
    div_sel = 3'd0;
  endtask

  task automatic t_normal();
    req(3'd1);
    cop_act = 1'b1; tick(2);
    chk("R6 held without sw_en", mode_o, 1);
    sw_en = 1'b1; pwr_save = 1'b1; tick(1);
    chk("R6 cop up", mode_o, 0);
    cop_act = 1'b0; tick(1);
    chk("R7 auto down", mode_o, 1);
    pwr_save = 1'b0; tick(1);
    chk("R6 power-save clear up", mode_o, 0);
    sw_en = 1'b0; pulse_tmr(4'b0001);
    sw_en = 1'b1; pwr_save = 1'b1; tick(2);
    chk("R7 blocked by flag", mode_o, 0);
    clr(2'b01);
    chk("R7 not yet down", mode_o, 0);
    tick(1);
    chk("R7 down after clear", mode_o, 1);
    sw_en = 1'b0; pwr_save = 1'b0;
    req(3'd0);
  endtask

  task automatic t_doze();
    sw_en = 1'b1;
    req(3'd3);
    chk("R8 doze-low", mode_o, 3);
    chk("R8 doze-low clk_hi", clk_hi, 0);
    cop_act = 1'b1; tick(1);
    chk("R8 doze up", mode_o, 2);
    chk("R8 doze-high clk_hi", clk_hi, 1);
    cop_act = 1'b0; tick(1);
    chk("R8 doze down", mode_o, 3);
    req(3'd0);
    chk("R2 request in doze ignored", mode_o, 3);
    sw_en = 1'b0; cop_act = 1'b1; tick(1);
    cop_act = 1'b0; tick(2);
    chk("R8 doze-high held without sw_en", mode_o, 2);
    hrst();
    chk("R11 hreset from doze", mode_o, 0);
  endtask

  task automatic t_deep_lock();
    req(3'd5);
    chk("R2 deep-sleep pll off", pll_en, 0);
    chk("R2 deep-sleep clk_hi", clk_hi, 0);
    irq_req = 1'b1; tick(1);
    chk("R9 pll on at wake", pll_en, 1);
    chk("R9 still deep-sleep", mode_o, 5);
    tick(5);
    chk("R9 waiting for lock", mode_o, 5);
    pll_lock = 1'b1; tick(1);
    chk("R9 exit on lock", mode_o, 0);
    chk("R9 latency", wake_lat, 6);
    pll_lock = 1'b0; irq_req = 1'b0;
  endtask

  task automatic t_deep_timeout();
    ref_tick = 1'b1; one_to_one = 1'b0;
    req(3'd5);
    pulse_tmr(4'b0010);
    tick(499);
    chk("R10 osc wait held", mode_o, 5);
    tick(1);
    chk("R10 osc timeout exit", mode_o, 0);
    chk("R10 osc latency", wake_lat, 500);
    clr(2'b01);
    one_to_one = 1'b1;
    req(3'd5);
    pulse_tmr(4'b0010);
    tick(999);
    chk("R10 ext wait held", mode_o, 5);
    tick(1);
    chk("R10 ext timeout exit", mode_o, 0);
    chk("R10 ext latency", wake_lat, 1000);
    clr(2'b01);
    ref_tick = 1'b0; one_to_one = 1'b0;
  endtask

  task automatic t_pdn();
    req(3'd6);
    chk("R2 power-down pll off", pll_en, 0);
    pulse_tmr(4'b0100);
    chk("R11 texp set", texp_flag, 1);
    chk("R11 pin high", tmr_exp_pin, 1);
    tick(3);
    chk("R11 stays power-down", mode_o, 6);
    hrst();
    chk("R11 hreset to normal-high", mode_o, 0);
    chk("R11 texp kept", texp_flag, 1);
    chk("R11 pll back on", pll_en, 1);
    clr(2'b10);
    chk("R14 texp cleared", texp_flag, 0);
    chk("R14 pin low", tmr_exp_pin, 0);
    chk("R14 twake untouched", twake_flag, 1);
    clr(2'b01);
  endtask

  task automatic t_pdn_hrst();
    req(3'd6);
    hrst();
    chk("R12 mode", mode_o, 0);
    chk("R12 texp set", texp_flag, 1);
    chk("R12 pin high", tmr_exp_pin, 1);
    chk("R12 twake clear", twake_flag, 0);
    clr(2'b10);
  endtask

  task automatic t_flag_entry();
    pulse_tmr(4'b1000);
    req(3'd4);
    chk("R13 sleep entered", mode_o, 4);
    tick(3);
    chk("R13 sleep before wake", mode_o, 4);
    tick(1);
    chk("R13 returned", mode_o, 0);
    chk("R13 latency", wake_lat, 3);
    clr(2'b01);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_requests();
    t_flag();
    t_tmr_wake();
    t_irq();
    t_normal();
    t_doze();
    t_deep_lock();
    t_deep_timeout();
    t_pdn();
    t_pdn_hrst();
    t_flag_entry();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule